// File: doc/BRIEF.md
# Deadline-Urgency Real-Time Grant Stage

This block is the first stage of a multi-level bus arbiter, the stage that serves masters with hard timing limits. When a master raises its request it also presents a deadline, which is a count of cycles within which the transfer must finish. A timer for that master loads the count and then counts down once per cycle for as long as the request stays up. A request is **urgent** when its remaining count has dropped to or below a warning threshold set for that master. Among the urgent requests, the one with the least remaining time receives a one-hot grant, and the valid flag tells the next stage down (a weighted lottery) to stand aside.

When no request is urgent, the grant vector is zero and the valid flag is low, so the weighted stage picks the winner. If a timer sits at zero and its request is still asserted, a sticky violation bit for that master goes high. Software clears the bit by writing a one to the matching clear input. The block does not model transfer timing: a master marks completion by lowering its request.

Top module: `edf_rt_guard`

## Requirements
- R1: On the first clock edge at which a master's request is seen high after being low, that master's counter loads its deadline input. A later re-assertion reloads it.
- R2: For each edge that the request stays high, the counter drops by one and stops at zero. While the request is low the counter is held at zero.
- R3: A master is urgent when its request is high, its counter has been loaded, and the counter value is less than or equal to its warning threshold. Only urgent masters can be granted.
- R4: The grant vector has at most one bit set. The valid flag is high exactly when a grant is given. With no urgent master, both the grant and the valid flag are zero.
- R5: Among the urgent masters, the one with the smallest counter value is granted.
- R6: When urgent masters tie on counter value, the lowest index wins.
- R7: A master's violation bit sets on the clock edge at which its counter is already zero and its request is still high.
- R8: A violation bit stays set until its own clear bit is high at a clock edge. Other bits are not affected. If a set and a clear fall on the same edge, the set wins.
- R9: After a synchronous active-low reset, all counters are zero, no grant is given, the valid flag is low and every violation bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_MST | Real-time request per master; lowering it marks completion |
| deadline_i | input | N_MST*CNT_W | Deadline per master, master i in bits [i*CNT_W +: CNT_W], sampled on request rise |
| warn_i | input | N_MST*CNT_W | Warning threshold per master, same packing |
| viol_clr_i | input | N_MST | Clear for each violation bit |
| gnt_o | output | N_MST | One-hot real-time grant |
| gnt_vld_o | output | 1 | High when this stage has made a grant |
| viol_o | output | N_MST | Sticky deadline-violation bits |

## Verification
The selection logic is exercised with several request patterns:
- All four masters requesting with no urgent master, which separates urgency gating from plain request presence.
- One master whose countdown alone brings it under the line, which shows the decrement.
- Two urgent masters with unequal counts, which shows minimum selection rather than an index order.
- Three-way ties, which expose the tie-break direction.
- Equal counts with different thresholds, which show that the threshold is per master.
- Masters that are not requesting but have small deadlines, which must be ignored.
- Counters saturated at zero, where both the tie rule and the stop at zero apply.

Directed sequences then cover the exact edge on which a violation sets, keeping the bit across a dropped request, clearing one bit while another stays, a set and a clear on the same edge, and a reload when a request is raised again.

// File: rtl/rtdl_pkg.sv
// Shared defaults for the deadline-urgency grant stage.
// Assumes: every module of the stage takes its sizes from these values.
package rtdl_pkg;
    localparam int unsigned RTDL_MASTERS = 4;
    localparam int unsigned RTDL_CNT_W   = 8;
endpackage

// File: rtl/rtdl_timer.sv
// Per-master deadline timer: loads the deadline on a request rise and counts
// down to zero while the request is held. Also flags urgency against the
// warning threshold and keeps a sticky violation bit.
// Assumes: the request stays high until the master's transfer is complete.
module rtdl_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [CW-1:0] dl_i,
    input  logic [CW-1:0] warn_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o,
    output logic          urg_o,
    output logic          viol_o
);
    logic          act_q;
    logic [CW-1:0] cnt_q;
    logic          viol_q;
    logic          expired;

    // Remember whether the request was already seen, to detect a rise.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= req_i;
    end

    // Load on rise, count down while held, stop at zero, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!req_i)         cnt_q <= '0;
        else if (!act_q)         cnt_q <= dl_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // A tracked request whose time has run out.
    always_comb expired = act_q & req_i & (cnt_q == '0);

    // Sticky violation bit; a set on the same edge overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       viol_q <= 1'b0;
        else if (expired) viol_q <= 1'b1;
        else if (clr_i)   viol_q <= 1'b0;
    end

    // Urgency: a tracked request at or under its warning line.
    always_comb urg_o = act_q & req_i & (cnt_q <= warn_i);

    assign cnt_o  = cnt_q;
    assign viol_o = viol_q;

    AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !act_q) |=> (cnt_q == $past(dl_i)));                    // R1
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && req_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i) |=> (cnt_q == '0));                                       // R2
    AST_VIOL_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && req_i && cnt_q == '0) |=> viol_q);                       // R7
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_q && !clr_i) |=> viol_q);                                    // R8
endmodule

// File: rtl/rtdl_pick.sv
// Earliest-deadline picker: among the urgent masters, grant the one with the
// smallest remaining count, choosing the lower index on a tie.
// Assumes: counts come from registers, so this path is a single comparison chain.
module rtdl_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  urg_i,
    input  logic [CW-1:0] cnt_i [N],
    output logic [N-1:0]  gnt_o,
    output logic          gnt_vld_o
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic          found;
    logic [CW-1:0] best;
    logic [IW-1:0] sel;

    // Linear scan: a strictly smaller count displaces the current best.
    always_comb begin
        found = 1'b0;
        best  = '0;
        sel   = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (urg_i[i] && (!found || cnt_i[i] < best)) begin
                found = 1'b1;
                best  = cnt_i[i];
                sel   = IW'(i);
            end
        end
    end

    // Expand the chosen index into a one-hot grant.
    always_comb begin
        gnt_o      = '0;
        gnt_o[sel] = found;
    end

    assign gnt_vld_o = found;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));                                                  // R4
    AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o == (gnt_o != '0));                                       // R4
    AST_GNT_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~urg_i) == '0);                                           // R3
    AST_URGENT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (urg_i != '0) |-> gnt_vld_o);                                      // R4

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            if (gj < gi) begin : g_lo
                AST_TIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                    (gnt_o[gi] && urg_i[gj]) |-> (cnt_i[gj] > cnt_i[gi]));  // R6
            end else if (gj > gi) begin : g_hi
                AST_MIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                    (gnt_o[gi] && urg_i[gj]) |-> (cnt_i[gj] >= cnt_i[gi])); // R5
            end
        end
    end
endmodule

// File: rtl/edf_rt_guard.sv
// Real-time grant stage: one deadline timer per master feeding an
// earliest-deadline picker. A grant here overrides the weighted stage below.
// Assumes: deadlines and thresholds are packed master 0 in the low bits.
module edf_rt_guard
    import rtdl_pkg::*;
#(
    parameter int unsigned N_MST = RTDL_MASTERS,
    parameter int unsigned CNT_W = RTDL_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_MST-1:0]       req_i,
    input  logic [N_MST*CNT_W-1:0] deadline_i,
    input  logic [N_MST*CNT_W-1:0] warn_i,
    input  logic [N_MST-1:0]       viol_clr_i,
    output logic [N_MST-1:0]       gnt_o,
    output logic                   gnt_vld_o,
    output logic [N_MST-1:0]       viol_o
);
    logic [CNT_W-1:0] cnt   [N_MST];
    logic [N_MST-1:0] urg;

    // One timer per master.
    for (genvar g = 0; g < N_MST; g++) begin : g_tmr
        rtdl_timer #(.CW(CNT_W)) i_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_i[g]),
            .dl_i   (deadline_i[g*CNT_W +: CNT_W]),
            .warn_i (warn_i[g*CNT_W +: CNT_W]),
            .clr_i  (viol_clr_i[g]),
            .cnt_o  (cnt[g]),
            .urg_o  (urg[g]),
            .viol_o (viol_o[g])
        );
    end

    // Earliest-deadline choice among urgent masters.
    rtdl_pick #(.N(N_MST), .CW(CNT_W)) i_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .urg_i     (urg),
        .cnt_i     (cnt),
        .gnt_o     (gnt_o),
        .gnt_vld_o (gnt_vld_o)
    );

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);                                           // R3
endmodule

// File: tb/test_edf_rt_guard.sv
module test_edf_rt_guard;
    localparam int N = 4;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [N*W-1:0] dl = '0;
    logic [N*W-1:0] warn = '0;
    logic [N-1:0]   clr = '0;
    logic [N-1:0]   gnt;
    logic           vld;
    logic [N-1:0]   viol;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    edf_rt_guard #(.N_MST(N), .CNT_W(W)) i_edf_rt_guard (
        .clk(clk), .rst_n(rst_n), .req_i(req), .deadline_i(dl), .warn_i(warn),
        .viol_clr_i(clr), .gnt_o(gnt), .gnt_vld_o(vld), .viol_o(viol)
    );

    // {req, dl3..dl0, warn3..warn0, edges, expected grant}
    localparam logic [79:0] VEC [8] = '{
        {4'b1111, 8'd40, 8'd30, 8'd20, 8'd10, 8'd5, 8'd5, 8'd5, 8'd5,       8'd1,  4'b0000}, // R3 none urgent
        {4'b1111, 8'd40, 8'd30, 8'd20, 8'd10, 8'd5, 8'd5, 8'd5, 8'd5,       8'd6,  4'b0001}, // R2 countdown
        {4'b1111, 8'd30, 8'd8,  8'd12, 8'd50, 8'd10,8'd10,8'd10,8'd10,      8'd3,  4'b0100}, // R5 min wins
        {4'b1111, 8'd7,  8'd7,  8'd7,  8'd20, 8'd8, 8'd8, 8'd8, 8'd8,       8'd1,  4'b0010}, // R6 tie low
        {4'b1111, 8'd30, 8'd30, 8'd30, 8'd30, 8'd29,8'd25,8'd0, 8'd0,       8'd3,  4'b1000}, // R3 per-master line
        {4'b0101, 8'd1,  8'd9,  8'd1,  8'd3,  8'd255,8'd255,8'd255,8'd255,  8'd1,  4'b0001}, // R3 idle ignored
        {4'b0011, 8'd0,  8'd0,  8'd4,  8'd2,  8'd255,8'd255,8'd255,8'd255,  8'd10, 4'b0001}, // R2 R6 at zero
        {4'b1000, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0, 8'd0, 8'd0, 8'd0,       8'd1,  4'b1000}  // R3 zero line
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_clear();
        req = '0;
        clr = '1;
        tick();
        clr = '0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick();
        tick();
        // R9: reset state
        chk(gnt == '0 && vld == 1'b0, "R9 grant after reset", {3'b0, vld, gnt}, 8'h0);
        chk(viol == '0, "R9 violation after reset", {4'b0, viol}, 8'h0);
        rst_n = 1'b1;
        tick();

        for (int v = 0; v < 8; v++) begin
            idle_clear();
            req  = VEC[v][79:76];
            dl   = VEC[v][75:44];
            warn = VEC[v][43:12];
            for (int e = 0; e < int'(VEC[v][11:4]); e++) tick();
            chk(gnt == VEC[v][3:0], $sformatf("R5 vector %0d grant", v), {4'b0, gnt}, {4'b0, VEC[v][3:0]});
            chk(vld == (VEC[v][3:0] != '0), $sformatf("R4 vector %0d valid", v), {7'b0, vld}, {7'b0, (VEC[v][3:0] != '0)});
        end

        // R7: violation edge for master 1, deadline 3
        idle_clear();
        req = 4'b0010; dl = {8'd0, 8'd0, 8'd3, 8'd0}; warn = '0;
        for (int e = 0; e < 4; e++) tick();
        chk(gnt == 4'b0010, "R3 zero count at zero line", {4'b0, gnt}, 8'h2);
        chk(viol == 4'b0000, "R7 no violation before expiry edge", {4'b0, viol}, 8'h0);
        tick();
        chk(viol == 4'b0010, "R7 violation at expiry edge", {4'b0, viol}, 8'h2);
        req = '0;
        tick();
        chk(viol == 4'b0010, "R8 sticky after request drop", {4'b0, viol}, 8'h2);
        chk(gnt == '0 && !vld, "R4 no grant when idle", {3'b0, vld, gnt}, 8'h0);

        // R8: partial clear
        req = 4'b0110; dl = '0;
        tick();
        tick();
        chk(viol == 4'b0110, "R7 two violations", {4'b0, viol}, 8'h6);
        req = '0; clr = 4'b0010;
        tick();
        clr = '0;
        chk(viol == 4'b0100, "R8 clear one bit only", {4'b0, viol}, 8'h4);

        // R8: set beats clear on the same edge
        req = 4'b1000; dl = '0;
        tick();
        clr = 4'b1000;
        tick();
        clr = '0;
        chk(viol == 4'b1100, "R8 set wins over clear", {4'b0, viol}, 8'hc);

        // R1: reload on re-assertion
        idle_clear();
        req = 4'b0001; dl = {24'd0, 8'd2}; warn = {24'd0, 8'd1};
        tick();
        chk(gnt == 4'b0000, "R1 loaded above line", {4'b0, gnt}, 8'h0);
        tick();
        chk(gnt == 4'b0001, "R2 one step under line", {4'b0, gnt}, 8'h1);
        req = '0;
        tick();
        req = 4'b0001; dl = {24'd0, 8'd9};
        tick();
        chk(gnt == 4'b0000 && !vld, "R1 reload on new request", {3'b0, vld, gnt}, 8'h0);

        // R9: reset clears violations and grant
        req = 4'b0001; dl = '0;
        tick(); tick();
        rst_n = 1'b0;
        req = '0;
        tick();
        chk(viol == '0 && gnt == '0, "R9 reset clears state", {viol, gnt}, 8'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule